// File: doc/BRIEF.md
# Windowed Instruction Register File

This block holds the register file that packed instructions index. Several windows of the same size live in one storage array, and an instruction-window pointer picks the window that the 5-bit read index sees. The low entries of the index space form a static region that every window shares. The rest of the index space is private to the active window, so each window shows 32 entries however many windows exist.

A call event carries a jump-target field. The top bits of that field name the window the callee uses, and the bits below them are the program-counter target, which the block passes out unchanged. On a call the block pushes the current pointer onto an internal return stack and moves to the named window. A return pops the stack and restores the saved pointer. Both changes take effect at the clock edge that ends the call or return cycle. If the stack is empty, a return selects window 0. If the stack is full, a call drops the oldest saved pointer. A load port writes one entry at a time. A static index reaches the shared slot and ignores the window operand. Entry 0 is a fixed no-operation word that no load can change.

The return stack is a small state machine with three states. STK_EMPTY holds no saved pointer. STK_PART holds at least one saved pointer and has free room. STK_FULL holds STK_DEPTH saved pointers. These are its transitions:
- push_first: a call in STK_EMPTY goes to STK_PART, or to STK_FULL when STK_DEPTH is 1.
- push_grow: a call in STK_PART stays in STK_PART.
- push_fill: a call in STK_PART that takes the last free slot goes to STK_FULL.
- push_drop: a call in STK_FULL stays in STK_FULL and discards the oldest entry.
- pop_shrink: a return in STK_PART with more than one entry stays in STK_PART.
- pop_last: a return in STK_PART with one entry goes to STK_EMPTY.
- pop_unfull: a return in STK_FULL goes to STK_PART, or to STK_EMPTY when STK_DEPTH is 1.
- pop_idle: a return in STK_EMPTY stays in STK_EMPTY and selects window 0.

Top module: `irfw_top`

## Requirements
- R1: After reset the window pointer is 0, the return stack is empty, and every entry other than entry 0 reads as zero.
- R2: A call (ev_valid=1, ev_ret=0) sets the window pointer at the next clock edge to the window field. The window field is the top WIN_W bits of ev_target, which are bits 25:24 with default parameters. A field value of NUM_WIN or more selects window 0.
- R3: A return (ev_valid=1, ev_ret=1) with a non-empty stack restores the pointer that was current before the matching call, in last-in first-out order, at the next clock edge.
- R4: A return with an empty stack sets the window pointer to 0.
- R5: The stack holds STK_DEPTH pointers. A call made when the stack is full discards the oldest saved pointer, so STK_DEPTH+1 nested calls unwind through STK_DEPTH restored windows and then reach window 0.
- R6: In a cycle without an event the window pointer holds its value.
- R7: A read index below STATIC_ENT returns the shared entry, whatever window is active.
- R8: A read index of STATIC_ENT or above returns that entry of the active window only. Entries of other windows have no effect on it.
- R9: A load with an index of STATIC_ENT or above writes only that entry of window ld_win. A load with an index of 1 to STATIC_ENT-1 writes the shared entry for all windows. The new value is readable from the next cycle.
- R10: Index 0 always reads NOP_WORD, and loads to index 0 have no effect.
- R11: pc_target always equals the low TGT_W-WIN_W bits of ev_target, which are bits 23:0 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A call or return executes this cycle |
| ev_ret | input | 1 | 1 = return, 0 = call (qualified by ev_valid) |
| ev_target | input | TGT_W | Jump-target field of the call: window in top bits, address below |
| pc_target | output | TGT_W-WIN_W | Address part of ev_target for the program counter |
| cur_win | output | WIN_W | Active window pointer |
| rd_idx | input | 5 | Instruction register index to read |
| rd_data | output | INST_W | Instruction word at rd_idx in the active window |
| ld_valid | input | 1 | Write one entry this cycle |
| ld_win | input | WIN_W | Window written by a windowed-index load |
| ld_idx | input | 5 | Entry index to write |
| ld_data | input | INST_W | Word to write |

## Verification
The assertions check several things on every clock edge. A call lands on the decoded window. A return from an empty stack lands on window 0. The pointer does not move without an event, and a full stack stays full under a further call. A completed load appears at its physical slot, and slot 0 stays frozen when a load targets index 0. A static read also stays steady across a window switch. Some behaviour shows only in the bench's scenarios. These are the last-in first-out order of restored windows across deep nesting, the loss of the oldest pointer on overflow, and the separation between windows of the same private index. Both directed sequences and a long constrained-random run check these against a reference model of the windows and the stack.

// File: rtl/irfw_pkg.sv
package irfw_pkg;

    localparam int VIS_ENT = 32;
    localparam int IDX_W   = 5;

    typedef enum logic [1:0] {
        STK_EMPTY = 2'd0,
        STK_PART  = 2'd1,
        STK_FULL  = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2
    } ev_kind_e;

    function automatic int win_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irfw_winptr.sv
module irfw_winptr
    import irfw_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int WIN_W     = 2,
    parameter int STK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic             ev_ret,
    input  logic [WIN_W-1:0] tgt_field,
    output logic [WIN_W-1:0] cur_win
);

    localparam int SP_W  = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
    localparam int CNT_W = $clog2(STK_DEPTH + 1);
    localparam logic [SP_W-1:0]  SP_LAST  = SP_W'(STK_DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STK_DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    stk_state_e       state, nxt_state;
    ev_kind_e         kind;
    logic [WIN_W-1:0] slot [STK_DEPTH];
    logic [SP_W-1:0]  sp, sp_inc, sp_dec;
    logic [CNT_W-1:0] cnt;
    logic [WIN_W-1:0] tgt_win;

    // event decode and target window range fold
    always_comb begin
        if (!ev_valid)   kind = EV_IDLE;
        else if (ev_ret) kind = EV_RET;
        else             kind = EV_CALL;
        tgt_win = (32'(tgt_field) < NUM_WIN) ? tgt_field : '0;
        sp_inc  = (sp == SP_LAST) ? '0 : sp + 1'b1;
        sp_dec  = (sp == '0) ? SP_LAST : sp - 1'b1;
    end

    // next-state logic of the return stack
    always_comb begin
        nxt_state = state;
        unique case (state)
            STK_EMPTY: begin
                if (kind == EV_CALL)
                    nxt_state = (STK_DEPTH == 1) ? STK_FULL : STK_PART;
            end
            STK_PART: begin
                if (kind == EV_CALL && cnt == CNT_FULL - CNT_ONE)
                    nxt_state = STK_FULL;
                else if (kind == EV_RET && cnt == CNT_ONE)
                    nxt_state = STK_EMPTY;
            end
            STK_FULL: begin
                if (kind == EV_RET)
                    nxt_state = (STK_DEPTH == 1) ? STK_EMPTY : STK_PART;
            end
            default: nxt_state = STK_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STK_EMPTY;
        else        state <= nxt_state;
    end

    // pointer, stack storage and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_win <= '0;
            sp      <= '0;
            cnt     <= '0;
            for (int i = 0; i < STK_DEPTH; i++) slot[i] <= '0;
        end else begin
            unique case (kind)
                EV_CALL: begin
                    slot[sp] <= cur_win;
                    sp       <= sp_inc;
                    cur_win  <= tgt_win;
                    if (state != STK_FULL) cnt <= cnt + CNT_ONE;
                end
                EV_RET: begin
                    if (state == STK_EMPTY) begin
                        cur_win <= '0;
                    end else begin
                        cur_win <= slot[sp_dec];
                        sp      <= sp_dec;
                        cnt     <= cnt - CNT_ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: a call lands on the decoded window field
    a_r2_call_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ret) |=> cur_win == $past(tgt_win));

    // R2: pointer never leaves the implemented windows
    a_r2_win_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cur_win) < NUM_WIN);

    // R4: empty-stack return selects window 0
    a_r4_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STK_EMPTY && ev_valid && ev_ret) |=> cur_win == '0);

    // R5: a call on a full stack keeps it full
    a_r5_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STK_FULL && ev_valid && !ev_ret) |=> state == STK_FULL);

    // R6: no event, no pointer movement
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(cur_win));

endmodule

// File: rtl/irfw_addr.sv
module irfw_addr
    import irfw_pkg::*;
#(
    parameter int NUM_WIN    = 4,
    parameter int STATIC_ENT = 8,
    parameter int WIN_W      = 2,
    parameter int PA_W       = 7
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [WIN_W-1:0] win,
    output logic [PA_W-1:0]  pa
);

    localparam int WIN_ENT = VIS_ENT - STATIC_ENT;

    int unsigned off;
    int unsigned wsel;

    always_comb begin
        wsel = (32'(win) < NUM_WIN) ? 32'(win) : 32'd0;
        if (32'(idx) < STATIC_ENT)
            off = 32'(idx);
        else
            off = wsel * WIN_ENT + 32'(idx);
        pa = PA_W'(off);
    end

endmodule

// File: rtl/irfw_store.sv
module irfw_store
    import irfw_pkg::*;
#(
    parameter int                INST_W   = 32,
    parameter int                PHYS     = 104,
    parameter int                PA_W     = 7,
    parameter logic [INST_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PA_W-1:0]   ld_pa,
    input  logic [INST_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [PA_W-1:0]   rd_pa,
    output logic [INST_W-1:0] rd_data
);

    logic [INST_W-1:0] mem [PHYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else if (ld_en && ld_idx != '0) begin
            mem[ld_pa] <= ld_data;
        end
    end

    always_comb rd_data = (rd_idx == '0) ? NOP_WORD : mem[rd_pa];

    // R9: a completed load is present at its slot one edge later
    a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_idx != '0) |=> mem[$past(ld_pa)] == $past(ld_data));

    // R10: a load to index 0 leaves slot 0 untouched
    a_r10_slot0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_idx == '0) |=> $stable(mem[0]));

endmodule

// File: rtl/irfw_top.sv
module irfw_top
    import irfw_pkg::*;
#(
    parameter int                NUM_WIN    = 4,
    parameter int                STATIC_ENT = 8,
    parameter int                INST_W     = 32,
    parameter int                TGT_W      = 26,
    parameter int                STK_DEPTH  = 4,
    parameter logic [INST_W-1:0] NOP_WORD   = '0,
    localparam int               WIN_W      = win_bits(NUM_WIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ev_valid,
    input  logic                   ev_ret,
    input  logic [TGT_W-1:0]       ev_target,
    output logic [TGT_W-WIN_W-1:0] pc_target,
    output logic [WIN_W-1:0]       cur_win,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [INST_W-1:0]      rd_data,
    input  logic                   ld_valid,
    input  logic [WIN_W-1:0]       ld_win,
    input  logic [IDX_W-1:0]       ld_idx,
    input  logic [INST_W-1:0]      ld_data
);

    localparam int WIN_ENT = VIS_ENT - STATIC_ENT;
    localparam int PHYS    = STATIC_ENT + NUM_WIN * WIN_ENT;
    localparam int PA_W    = $clog2(PHYS);

    logic [WIN_W-1:0] tgt_field;
    logic [PA_W-1:0]  rd_pa, ld_pa;

    // window field on top, program-counter part below
    assign tgt_field = ev_target[TGT_W-1 -: WIN_W];
    assign pc_target = ev_target[TGT_W-WIN_W-1:0];

    irfw_winptr #(
        .NUM_WIN   (NUM_WIN),
        .WIN_W     (WIN_W),
        .STK_DEPTH (STK_DEPTH)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_ret    (ev_ret),
        .tgt_field (tgt_field),
        .cur_win   (cur_win)
    );

    irfw_addr #(
        .NUM_WIN    (NUM_WIN),
        .STATIC_ENT (STATIC_ENT),
        .WIN_W      (WIN_W),
        .PA_W       (PA_W)
    ) u_rd_map (
        .idx (rd_idx),
        .win (cur_win),
        .pa  (rd_pa)
    );

    irfw_addr #(
        .NUM_WIN    (NUM_WIN),
        .STATIC_ENT (STATIC_ENT),
        .WIN_W      (WIN_W),
        .PA_W       (PA_W)
    ) u_ld_map (
        .idx (ld_idx),
        .win (ld_win),
        .pa  (ld_pa)
    );

    irfw_store #(
        .INST_W   (INST_W),
        .PHYS     (PHYS),
        .PA_W     (PA_W),
        .NOP_WORD (NOP_WORD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_valid),
        .ld_idx  (ld_idx),
        .ld_pa   (ld_pa),
        .ld_data (ld_data),
        .rd_idx  (rd_idx),
        .rd_pa   (rd_pa),
        .rd_data (rd_data)
    );

    // R8: a private index never resolves into the shared region
    a_r8_private_slot: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rd_idx) >= STATIC_ENT |-> 32'(rd_pa) >= STATIC_ENT);

    // R7: a shared entry read is unaffected by a window switch
    a_r7_static_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid && 32'(rd_idx) < STATIC_ENT)
            |=> (rd_idx != $past(rd_idx)) || $stable(rd_data));

endmodule

// File: tb/sim_irfw_top.sv
`timescale 1ns/1ps
module sim_irfw_top;

    localparam int NW    = 4;
    localparam int SE    = 8;
    localparam int DEPTH = 4;
    localparam int TW    = 26;
    localparam int WW    = 2;
    localparam int LOW_W = TW - WW;
    localparam logic [31:0] NOP = 32'hC0DE_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0, ev_ret = 1'b0;
    logic [TW-1:0]     ev_target = '0;
    logic [LOW_W-1:0]  pc_target;
    logic [WW-1:0]     cur_win;
    logic [4:0]        rd_idx = '0;
    logic [31:0]       rd_data;
    logic              ld_valid = 1'b0;
    logic [WW-1:0]     ld_win = '0;
    logic [4:0]        ld_idx = '0;
    logic [31:0]       ld_data = '0;

    int nchk = 0, nerr = 0, cyc = 0;

    logic [31:0] mdl [NW][32];
    int          mwin;
    int          stk[$];

    irfw_top #(
        .NUM_WIN(NW), .STATIC_ENT(SE), .INST_W(32), .TGT_W(TW),
        .STK_DEPTH(DEPTH), .NOP_WORD(NOP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ret(ev_ret),
        .ev_target(ev_target), .pc_target(pc_target), .cur_win(cur_win),
        .rd_idx(rd_idx), .rd_data(rd_data), .ld_valid(ld_valid),
        .ld_win(ld_win), .ld_idx(ld_idx), .ld_data(ld_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=150000", cyc);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input int w, input int i);
        if (i == 0) return NOP;
        return mdl[w][i];
    endfunction

    function automatic string rtag(input int i);
        if (i == 0)  return "R10 entry 0";
        if (i < SE)  return "R7 shared read";
        return "R8 windowed read";
    endfunction

    task automatic model_clear();
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 32; i++) mdl[w][i] = '0;
        mwin = 0;
        stk.delete();
    endtask

    task automatic peek(input int i, input logic [31:0] exp, input string tag);
        rd_idx = 5'(i);
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    // drive one cycle; called just after a negedge, returns just after the next
    task automatic cycle(input bit ev, input bit ret, input int w, input bit ld,
                         input int lw, input int li, input logic [31:0] d, input int ridx);
        string t;
        ev_valid  = ev;
        ev_ret    = ret;
        ev_target = {WW'(w), LOW_W'($urandom)};
        ld_valid  = ld;
        ld_win    = WW'(lw);
        ld_idx    = 5'(li);
        ld_data   = d;
        #0.5;
        chk("R11 pc_target", 32'(pc_target), 32'(ev_target[LOW_W-1:0]));
        t = "R6 hold";
        if (ev) begin
            if (!ret) begin
                t = "R2 call";
                if (stk.size() == DEPTH) stk.delete(0);
                stk.push_back(mwin);
                mwin = w;
            end else if (stk.size() == 0) begin
                t = "R4 empty return";
                mwin = 0;
            end else begin
                t = "R3 return";
                mwin = stk.pop_back();
            end
        end
        if (ld && li != 0) begin
            if (li < SE) for (int k = 0; k < NW; k++) mdl[k][li] = d;
            else         mdl[lw][li] = d;
        end
        @(negedge clk);
        ev_valid = 1'b0;
        ld_valid = 1'b0;
        rd_idx   = 5'(ridx);
        #0.5;
        chk(t, 32'(cur_win), 32'(mwin));
        chk(rtag(ridx), rd_data, mread(mwin, ridx));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        do_reset();

        // R1 reset state
        chk("R1 reset pointer", 32'(cur_win), 32'd0);
        peek(9, 32'd0, "R1 reset entry");
        peek(27, 32'd0, "R1 reset entry");
        peek(0, NOP, "R10 nop after reset");

        // R9 / R7: static load via window operand 2 is shared
        cycle(0, 0, 0, 1, 2, 3, 32'hA5A5_0003, 3);
        peek(3, 32'hA5A5_0003, "R9 static load visible in window 0");
        // R9 / R8: private load into window 1
        cycle(0, 0, 0, 1, 1, 20, 32'hB0B0_0020, 20);
        peek(20, 32'd0, "R8 window 0 untouched by window 1 load");
        // R2: call into window 1
        cycle(1, 0, 1, 0, 0, 0, 0, 20);
        chk("R2 call to window 1", 32'(cur_win), 32'd1);
        peek(20, 32'hB0B0_0020, "R8 window 1 private entry");
        peek(3, 32'hA5A5_0003, "R7 shared entry in window 1");
        // R10: load to index 0 ignored
        cycle(0, 0, 0, 1, 1, 0, 32'hDEAD_BEEF, 0);
        peek(0, NOP, "R10 load to entry 0 ignored");
        // R6
        cycle(0, 0, 0, 0, 0, 0, 0, 5);
        chk("R6 pointer held", 32'(cur_win), 32'd1);
        // R3, R4
        cycle(1, 1, 0, 0, 0, 0, 0, 20);
        chk("R3 return to window 0", 32'(cur_win), 32'd0);
        peek(20, 32'd0, "R8 back in window 0");
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R4 empty return", 32'(cur_win), 32'd0);

        // R5 overflow: five nested calls, depth four
        cycle(1, 0, 1, 0, 0, 0, 0, 1);
        cycle(1, 0, 2, 0, 0, 0, 0, 1);
        cycle(1, 0, 3, 0, 0, 0, 0, 1);
        cycle(1, 0, 1, 0, 0, 0, 0, 1);
        cycle(1, 0, 2, 0, 0, 0, 0, 1);
        chk("R5 deepest window", 32'(cur_win), 32'd2);
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 unwind 1", 32'(cur_win), 32'd1);
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 unwind 2", 32'(cur_win), 32'd3);
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 unwind 3", 32'(cur_win), 32'd2);
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 unwind 4", 32'(cur_win), 32'd1);
        cycle(1, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 oldest dropped, window 0", 32'(cur_win), 32'd0);

        // constrained random mix against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit ev, ret, ld;
            r   = int'($urandom_range(0, 99));
            ev  = (r < 45);
            ret = ev && (r < 20);
            ld  = ($urandom_range(0, 1) == 1);
            cycle(ev, ret, int'($urandom_range(0, NW - 1)), ld,
                  int'($urandom_range(0, NW - 1)), int'($urandom_range(0, 31)),
                  $urandom, int'($urandom_range(0, 31)));
        end

        // R1 again: reset mid-run clears entries and stack
        do_reset();
        chk("R1 pointer after second reset", 32'(cur_win), 32'd0);
        peek(3, 32'd0, "R1 shared entry cleared");
        cycle(1, 1, 0, 0, 0, 0, 0, 20);
        chk("R1 stack empty after reset", 32'(cur_win), 32'd0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule